// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

A synchronous two-port memory in which each port has its own clock, enable, write enable, address, data and parity inputs, and a registered data and parity output. Both ports can read and write any location. A per-port mode parameter decides what that port's output register shows on a write edge. In write-first mode it shows the incoming word. In read-first mode it shows the word the location held before the write. In no-change mode the output keeps its previous value.

Each port also has a synchronous set/reset. When the port is enabled, this loads the output register with a parameter value, and a write still goes to the array. When one port writes a location that the other port accesses on the same edge, the result at the other port depends on the writing port's mode. A read-first writer leaves the old word readable. Any other writer makes the other port's output invalid, and that port raises a one-cycle collision flag. The parity lane follows the data lane with identical timing.

Top module: `dpram_wm`

## Requirements
- R1: On an edge where a port's enable is low, that port neither reads nor writes: its data and parity outputs keep their values, its collision flag is 0 after the edge, and the addressed location is unchanged.
- R2: With enable high, write enable low and no set/reset, the output registers take the stored word at the address one edge later.
- R3: A port in write-first mode (mode code 0) stores the input word on a write, and its outputs show that same word after the edge.
- R4: A port in read-first mode (mode code 1) stores the input word on a write, and its outputs show the word the location held before the edge.
- R5: A port in no-change mode (mode code 2) stores the input word on a write, and its outputs keep their previous values.
- R6: The parity outputs follow the same rules as the data outputs in every case, one edge after the access.
- R7: When the other port writes the same address on the same edge and the other port's mode is write-first or no-change, an enabled port's output is invalid (X) and its collision flag is 1 after the edge. This does not apply while that port is in set/reset.
- R8: When the other port writes the same address on the same edge in read-first mode, a reading port receives the old stored word and its collision flag stays 0.
- R9: Set/reset asserted with enable high loads the data output with the port's data reset parameter and the parity output with its parity reset parameter, overriding the read or write result. A write with write enable high still updates the array.
- R10: While rst_ni is low, the output registers hold the reset parameters and the collision flags are 0. After reset, every location reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| srst_a_i | input | 1 | Port A synchronous output set/reset |
| addr_a_i | input | AW | Port A address |
| din_a_i | input | DW | Port A write data |
| dinp_a_i | input | PW | Port A write parity |
| dout_a_o | output | DW | Port A registered read data |
| doutp_a_o | output | PW | Port A registered read parity |
| coll_a_o | output | 1 | Port A output invalidated by a collision |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| srst_b_i | input | 1 | Port B synchronous output set/reset |
| addr_b_i | input | AW | Port B address |
| din_b_i | input | DW | Port B write data |
| dinp_b_i | input | PW | Port B write parity |
| dout_b_o | output | DW | Port B registered read data |
| doutp_b_o | output | PW | Port B registered read parity |
| coll_b_o | output | 1 | Port B output invalidated by a collision |

## Verification
The hardest case to reach is two ports touching the same word on the same edge, with one of them writing. It only happens when both clocks line up and the addresses match. The bench drives both ports from one clock and draws most addresses from a pool of eight words plus the top word, so overlaps are frequent. Two instances run side by side, one with write-first/read-first ports and one with no-change/write-first ports. Together they cover every writer mode against a reading or set/reset neighbour. Simultaneous writes to one word are steered away, since their stored result is not defined.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/dpram_store.sv
`timescale 1ns/1ps
// Two single-writer banks; per-word tag pair tells which port wrote last.
module dpram_store #(
  parameter int WW = 9,
  parameter int AW = 9
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          wr_a_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [WW-1:0] wdat_a_i,
  output logic [WW-1:0] rdat_a_o,
  input  logic          wr_b_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [WW-1:0] wdat_b_i,
  output logic [WW-1:0] rdat_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0]    bank_a [DEPTH];
  logic [WW-1:0]    bank_b [DEPTH];
  logic [DEPTH-1:0] tag_a;
  logic [DEPTH-1:0] tag_b;

  // tags equal -> A wrote last
  always_ff @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) bank_a[i] <= '0;
      tag_a <= '0;
    end else if (wr_a_i) begin
      bank_a[addr_a_i] <= wdat_a_i;
      tag_a[addr_a_i]  <= tag_b[addr_a_i];
    end
  end

  // tags differ -> B wrote last
  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) bank_b[i] <= '0;
      tag_b <= '0;
    end else if (wr_b_i) begin
      bank_b[addr_b_i] <= wdat_b_i;
      tag_b[addr_b_i]  <= ~tag_a[addr_b_i];
    end
  end

  assign rdat_a_o = (tag_a[addr_a_i] == tag_b[addr_a_i]) ? bank_a[addr_a_i] : bank_b[addr_a_i];
  assign rdat_b_o = (tag_a[addr_b_i] == tag_b[addr_b_i]) ? bank_a[addr_b_i] : bank_b[addr_b_i];
endmodule

// File: rtl/dpram_port.sv
`timescale 1ns/1ps
module dpram_port
  import dpram_pkg::*;
#(
  parameter int             WW       = 9,
  parameter wr_mode_e       MODE     = WM_WRITE_FIRST,
  parameter logic [WW-1:0]  RST_WORD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          srst_i,
  input  logic          hit_i,
  input  logic [WW-1:0] wdat_i,
  input  logic [WW-1:0] rdat_i,
  output logic [WW-1:0] dout_o,
  output logic          coll_o
);
  logic [WW-1:0] dout_q;
  logic [WW-1:0] wr_view;
  logic          coll_q;

  generate
    if (MODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_view = wdat_i;
    end else if (MODE == WM_READ_FIRST) begin : g_rf
      assign wr_view = rdat_i;
    end else begin : g_nc
      assign wr_view = dout_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= RST_WORD;
      coll_q <= 1'b0;
    end else begin
      coll_q <= en_i & hit_i & ~srst_i;
      if (en_i) begin
        if (srst_i)     dout_q <= RST_WORD;
        else if (hit_i) dout_q <= 'x;
        else if (we_i)  dout_q <= wr_view;
        else            dout_q <= rdat_i;
      end
    end
  end

  assign dout_o = dout_q;
  assign coll_o = coll_q;
endmodule

// File: rtl/dpram_wm.sv
`timescale 1ns/1ps
module dpram_wm
  import dpram_pkg::*;
#(
  parameter int             DW         = 8,
  parameter int             PW         = 1,
  parameter int             AW         = 9,
  parameter wr_mode_e       MODE_A     = WM_WRITE_FIRST,
  parameter wr_mode_e       MODE_B     = WM_READ_FIRST,
  parameter logic [DW-1:0]  RST_DATA_A = '0,
  parameter logic [PW-1:0]  RST_PAR_A  = '0,
  parameter logic [DW-1:0]  RST_DATA_B = '0,
  parameter logic [PW-1:0]  RST_PAR_B  = '0
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          en_a_i,
  input  logic          we_a_i,
  input  logic          srst_a_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [DW-1:0] din_a_i,
  input  logic [PW-1:0] dinp_a_i,
  output logic [DW-1:0] dout_a_o,
  output logic [PW-1:0] doutp_a_o,
  output logic          coll_a_o,
  input  logic          en_b_i,
  input  logic          we_b_i,
  input  logic          srst_b_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [DW-1:0] din_b_i,
  input  logic [PW-1:0] dinp_b_i,
  output logic [DW-1:0] dout_b_o,
  output logic [PW-1:0] doutp_b_o,
  output logic          coll_b_o
);
  localparam int  WW      = DW + PW;
  localparam bit  A_KILLS = (MODE_A != WM_READ_FIRST);
  localparam bit  B_KILLS = (MODE_B != WM_READ_FIRST);

  logic [WW-1:0] rdat_a, rdat_b, word_a, word_b;
  logic          hit_a, hit_b;

  // hit_x: other port writes this port's address with an invalidating mode
  assign hit_a = en_b_i & we_b_i & (addr_a_i == addr_b_i) & B_KILLS;
  assign hit_b = en_a_i & we_a_i & (addr_a_i == addr_b_i) & A_KILLS;

  dpram_store #(.WW(WW), .AW(AW)) i_store (
    .clk_a_i  (clk_a_i),
    .clk_b_i  (clk_b_i),
    .rst_ni   (rst_ni),
    .wr_a_i   (en_a_i & we_a_i),
    .addr_a_i (addr_a_i),
    .wdat_a_i ({dinp_a_i, din_a_i}),
    .rdat_a_o (rdat_a),
    .wr_b_i   (en_b_i & we_b_i),
    .addr_b_i (addr_b_i),
    .wdat_b_i ({dinp_b_i, din_b_i}),
    .rdat_b_o (rdat_b)
  );

  dpram_port #(.WW(WW), .MODE(MODE_A), .RST_WORD({RST_PAR_A, RST_DATA_A})) i_port_a (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .en_i   (en_a_i),
    .we_i   (we_a_i),
    .srst_i (srst_a_i),
    .hit_i  (hit_a),
    .wdat_i ({dinp_a_i, din_a_i}),
    .rdat_i (rdat_a),
    .dout_o (word_a),
    .coll_o (coll_a_o)
  );

  dpram_port #(.WW(WW), .MODE(MODE_B), .RST_WORD({RST_PAR_B, RST_DATA_B})) i_port_b (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .en_i   (en_b_i),
    .we_i   (we_b_i),
    .srst_i (srst_b_i),
    .hit_i  (hit_b),
    .wdat_i ({dinp_b_i, din_b_i}),
    .rdat_i (rdat_b),
    .dout_o (word_b),
    .coll_o (coll_b_o)
  );

  assign dout_a_o  = word_a[DW-1:0];
  assign doutp_a_o = word_a[WW-1:DW];
  assign dout_b_o  = word_b[DW-1:0];
  assign doutp_b_o = word_b[WW-1:DW];
endmodule

// File: rtl/dpram_wm_chk.sv
`timescale 1ns/1ps
module dpram_wm_chk
  import dpram_pkg::*;
#(
  parameter int             DW         = 8,
  parameter int             PW         = 1,
  parameter int             AW         = 9,
  parameter wr_mode_e       MODE_A     = WM_WRITE_FIRST,
  parameter wr_mode_e       MODE_B     = WM_READ_FIRST,
  parameter logic [DW-1:0]  RST_DATA_A = '0,
  parameter logic [PW-1:0]  RST_PAR_A  = '0,
  parameter logic [DW-1:0]  RST_DATA_B = '0,
  parameter logic [PW-1:0]  RST_PAR_B  = '0
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic          en_a_i,
  input logic          we_a_i,
  input logic          srst_a_i,
  input logic [AW-1:0] addr_a_i,
  input logic [DW-1:0] din_a_i,
  input logic [PW-1:0] dinp_a_i,
  input logic [DW-1:0] dout_a_o,
  input logic [PW-1:0] doutp_a_o,
  input logic          coll_a_o,
  input logic          en_b_i,
  input logic          we_b_i,
  input logic          srst_b_i,
  input logic [AW-1:0] addr_b_i,
  input logic [DW-1:0] din_b_i,
  input logic [PW-1:0] dinp_b_i,
  input logic [DW-1:0] dout_b_o,
  input logic [PW-1:0] doutp_b_o,
  input logic          coll_b_o
);
  logic same, b_writes, a_writes;
  assign same     = (addr_a_i == addr_b_i);
  assign b_writes = en_b_i && we_b_i && same;
  assign a_writes = en_a_i && we_a_i && same;

  // R1
  hold_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !en_a_i |=> $stable(dout_a_o) && $stable(doutp_a_o) && !coll_a_o);
  // R1
  hold_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !en_b_i |=> $stable(dout_b_o) && $stable(doutp_b_o) && !coll_b_o);
  // R9
  srst_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    en_a_i && srst_a_i |=> dout_a_o == RST_DATA_A && doutp_a_o == RST_PAR_A && !coll_a_o);
  // R9
  srst_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    en_b_i && srst_b_i |=> dout_b_o == RST_DATA_B && doutp_b_o == RST_PAR_B && !coll_b_o);

  generate
    if (MODE_A == WM_WRITE_FIRST) begin : g_a_wf
      // R3
      wf_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
        en_a_i && we_a_i && !srst_a_i && !(b_writes && MODE_B != WM_READ_FIRST)
        |=> dout_a_o == $past(din_a_i) && doutp_a_o == $past(dinp_a_i));
    end else if (MODE_A == WM_NO_CHANGE) begin : g_a_nc
      // R5
      nc_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
        en_a_i && we_a_i && !srst_a_i && !(b_writes && MODE_B != WM_READ_FIRST)
        |=> $stable(dout_a_o) && $stable(doutp_a_o));
    end
    if (MODE_B == WM_WRITE_FIRST) begin : g_b_wf
      // R3
      wf_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
        en_b_i && we_b_i && !srst_b_i && !(a_writes && MODE_A != WM_READ_FIRST)
        |=> dout_b_o == $past(din_b_i) && doutp_b_o == $past(dinp_b_i));
    end else if (MODE_B == WM_NO_CHANGE) begin : g_b_nc
      // R5
      nc_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
        en_b_i && we_b_i && !srst_b_i && !(a_writes && MODE_A != WM_READ_FIRST)
        |=> $stable(dout_b_o) && $stable(doutp_b_o));
    end
    if (MODE_B != WM_READ_FIRST) begin : g_a_kill
      // R7
      coll_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
        en_a_i && !srst_a_i && b_writes |=> coll_a_o);
    end else begin : g_a_keep
      // R8
      nocoll_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
        en_a_i |=> !coll_a_o);
    end
    if (MODE_A != WM_READ_FIRST) begin : g_b_kill
      // R7
      coll_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
        en_b_i && !srst_b_i && a_writes |=> coll_b_o);
    end else begin : g_b_keep
      // R8
      nocoll_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
        en_b_i |=> !coll_b_o);
    end
  endgenerate
endmodule

bind dpram_wm dpram_wm_chk #(
  .DW(DW), .PW(PW), .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B),
  .RST_DATA_A(RST_DATA_A), .RST_PAR_A(RST_PAR_A),
  .RST_DATA_B(RST_DATA_B), .RST_PAR_B(RST_PAR_B)
) i_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .en_a_i(en_a_i), .we_a_i(we_a_i), .srst_a_i(srst_a_i), .addr_a_i(addr_a_i),
  .din_a_i(din_a_i), .dinp_a_i(dinp_a_i), .dout_a_o(dout_a_o), .doutp_a_o(doutp_a_o),
  .coll_a_o(coll_a_o),
  .en_b_i(en_b_i), .we_b_i(we_b_i), .srst_b_i(srst_b_i), .addr_b_i(addr_b_i),
  .din_b_i(din_b_i), .dinp_b_i(dinp_b_i), .dout_b_o(dout_b_o), .doutp_b_o(doutp_b_o),
  .coll_b_o(coll_b_o)
);

// File: tb/test_dpram_wm.sv
`timescale 1ns/1ps
module test_dpram_wm;
  import dpram_pkg::*;
  localparam int DW = 8;
  localparam int PW = 1;
  localparam int AW = 9;
  localparam int WW = DW + PW;
  localparam logic [DW-1:0] RDA = 8'hA5;
  localparam logic [PW-1:0] RPA = 1'b1;
  localparam logic [DW-1:0] RDB = 8'h3C;
  localparam logic [PW-1:0] RPB = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]    en, we, sr;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] din  [2];
  logic [PW-1:0] dinp [2];
  logic [DW-1:0] dout  [2][2];
  logic [PW-1:0] doutp [2][2];
  logic          coll  [2][2];

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [WW-1:0] ref_mem [1<<AW];
  logic [WW-1:0] exp_w [2][2];
  bit            exp_c [2][2];
  bit            exp_x [2][2];
  string         req_s [2][2];

  // instance 0: A write-first, B read-first
  dpram_wm #(.DW(DW), .PW(PW), .AW(AW), .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST),
    .RST_DATA_A(RDA), .RST_PAR_A(RPA), .RST_DATA_B(RDB), .RST_PAR_B(RPB)) i_dpram_wm (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .en_a_i(en[0]), .we_a_i(we[0]), .srst_a_i(sr[0]), .addr_a_i(addr[0]),
    .din_a_i(din[0]), .dinp_a_i(dinp[0]),
    .dout_a_o(dout[0][0]), .doutp_a_o(doutp[0][0]), .coll_a_o(coll[0][0]),
    .en_b_i(en[1]), .we_b_i(we[1]), .srst_b_i(sr[1]), .addr_b_i(addr[1]),
    .din_b_i(din[1]), .dinp_b_i(dinp[1]),
    .dout_b_o(dout[0][1]), .doutp_b_o(doutp[0][1]), .coll_b_o(coll[0][1]));

  // instance 1: A no-change, B write-first
  dpram_wm #(.DW(DW), .PW(PW), .AW(AW), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST),
    .RST_DATA_A(RDA), .RST_PAR_A(RPA), .RST_DATA_B(RDB), .RST_PAR_B(RPB)) i_dpram_wm_nc (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_n),
    .en_a_i(en[0]), .we_a_i(we[0]), .srst_a_i(sr[0]), .addr_a_i(addr[0]),
    .din_a_i(din[0]), .dinp_a_i(dinp[0]),
    .dout_a_o(dout[1][0]), .doutp_a_o(doutp[1][0]), .coll_a_o(coll[1][0]),
    .en_b_i(en[1]), .we_b_i(we[1]), .srst_b_i(sr[1]), .addr_b_i(addr[1]),
    .din_b_i(din[1]), .dinp_b_i(dinp[1]),
    .dout_b_o(dout[1][1]), .doutp_b_o(doutp[1][1]), .coll_b_o(coll[1][1]));

  function automatic wr_mode_e mode_of(input int d, input int p);
    if (d == 0) return (p == 0) ? WM_WRITE_FIRST : WM_READ_FIRST;
    return (p == 0) ? WM_NO_CHANGE : WM_WRITE_FIRST;
  endfunction

  function automatic logic [WW-1:0] rst_word(input int p);
    return (p == 0) ? {RPA, RDA} : {RPB, RDB};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic set_port(input int p, input bit e, input bit w, input bit s,
                          input logic [AW-1:0] a, input logic [DW-1:0] dd, input logic [PW-1:0] pp);
    en[p] = e; we[p] = w; sr[p] = s; addr[p] = a; din[p] = dd; dinp[p] = pp;
  endtask

  // called at a falling edge with inputs applied
  task automatic step();
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        int o = 1 - p;
        bit same_w = en[o] && we[o] && (addr[o] == addr[p]);
        bit hit = same_w && (mode_of(d, o) != WM_READ_FIRST);
        logic [WW-1:0] old = ref_mem[addr[p]];
        if (!en[p]) begin
          exp_c[d][p] = 1'b0; req_s[d][p] = "R1";
        end else if (sr[p]) begin
          exp_w[d][p] = rst_word(p); exp_x[d][p] = 1'b0; exp_c[d][p] = 1'b0; req_s[d][p] = "R9";
        end else if (hit) begin
          exp_x[d][p] = 1'b1; exp_c[d][p] = 1'b1; req_s[d][p] = "R7";
        end else begin
          exp_c[d][p] = 1'b0;
          if (we[p]) begin
            case (mode_of(d, p))
              WM_WRITE_FIRST: begin exp_w[d][p] = {dinp[p], din[p]}; exp_x[d][p] = 1'b0; req_s[d][p] = "R3"; end
              WM_READ_FIRST:  begin exp_w[d][p] = old; exp_x[d][p] = 1'b0; req_s[d][p] = "R4"; end
              default:        req_s[d][p] = "R5";
            endcase
          end else begin
            exp_w[d][p] = old; exp_x[d][p] = 1'b0;
            req_s[d][p] = same_w ? "R8" : "R2";
          end
        end
      end
    end
    for (int p = 0; p < 2; p++)
      if (en[p] && we[p]) ref_mem[addr[p]] = {dinp[p], din[p]};
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        if (!exp_x[d][p]) begin
          check(req_s[d][p], 32'(dout[d][p]), 32'(exp_w[d][p][DW-1:0]));
          check("R6", 32'(doutp[d][p]), 32'(exp_w[d][p][WW-1:DW]));
        end
        check(req_s[d][p], 32'(coll[d][p]), 32'(exp_c[d][p]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++) begin
        exp_w[d][p] = rst_word(p); exp_c[d][p] = 1'b0; exp_x[d][p] = 1'b0; req_s[d][p] = "R10";
      end
    set_port(0, 0, 0, 0, '0, '0, '0);
    set_port(1, 0, 0, 0, '0, '0, '0);
    repeat (4) @(negedge clk);
    // R10: reset values while held and after release
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++) begin
        check("R10", {23'b0, doutp[d][p], dout[d][p]}, {23'b0, rst_word(p)});
        check("R10", 32'(coll[d][p]), 32'd0);
      end
    rst_n = 1'b1;
    @(negedge clk);

    // R10: array reads zero after reset
    set_port(0, 1, 0, 0, 9'd3, '0, '0);
    set_port(1, 1, 0, 0, 9'd511, '0, '0);
    step();
    // R3/R5: port A write, B idle
    set_port(0, 1, 1, 0, 9'd5, 8'h11, 1'b1);
    set_port(1, 0, 0, 0, 9'd0, '0, '0);
    step();
    // R8 (inst 0) / R7 (inst 1): B writes 5 while A reads 5
    set_port(0, 1, 0, 0, 9'd5, '0, '0);
    set_port(1, 1, 1, 0, 9'd5, 8'h22, 1'b0);
    step();
    // R7: A writes 5 while B reads 5
    set_port(0, 1, 1, 0, 9'd5, 8'h33, 1'b1);
    set_port(1, 1, 0, 0, 9'd5, '0, '0);
    step();
    // R9: set/reset with writes to other addresses
    set_port(0, 1, 1, 1, 9'd6, 8'h44, 1'b0);
    set_port(1, 1, 1, 1, 9'd7, 8'h55, 1'b1);
    step();
    // R1: disabled write must not land
    set_port(0, 0, 1, 0, 9'd6, 8'hEE, 1'b1);
    set_port(1, 0, 1, 0, 9'd7, 8'hDD, 1'b0);
    step();
    // R9 write landed, R1 write did not
    set_port(0, 1, 0, 0, 9'd6, '0, '0);
    set_port(1, 1, 0, 0, 9'd7, '0, '0);
    step();

    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++) begin
        logic [AW-1:0] a = ($urandom_range(0, 4) == 0) ? 9'd511 : 9'($urandom_range(0, 7));
        set_port(p, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 7) == 0, a, 8'($urandom()), 1'($urandom()));
      end
      if (en[0] && en[1] && we[0] && we[1] && addr[0] == addr[1]) we[1] = 1'b0;
      step();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule